// File: doc/BRIEF.md
# Dual Programmable Sample-Rate Generator

This block turns a fixed 48 kHz frame tick into four sample strobes, one each for ADC left, ADC right, DAC left and DAC right. Two independent generators each hold a sample rate in whole hertz. Every frame tick, each generator decides whether its channels take a sample in that frame. A channel running below 48 kHz skips some frames so that, on average, it fires at its programmed rate.

A control register maps every channel to either generator. The same register can scale the second generator's rate by 8/7 or 10/7, which produces the irrational rates that modem data pumps need. The first generator always runs at its programmed rate.

Software uses a simple write port and a combinational read port, both indexed by an 8-bit register address. A new rate takes effect from the next frame tick. Writing a rate register restarts that generator's phase from zero. Values outside the 7000 to 48000 Hz range are not clamped. Their behaviour is left to the caller.

Top module: `dual_srgen`

## Requirements
- R1: After reset both rate registers read 48000 (BB80h), the control register reads 0000h, and all four strobes are low.
- R2: The rate for generator 0 sits at address 78h and the rate for generator 1 at 7Ah. The control register sits at 76h. It reads back all 16 bits as written, including reserved bits, so that software can do read-modify-write.
- R3: The threshold is T = 336000. On every frame tick a generator adds its numerator N to an accumulator; for generator 0, N is rate×7. Count k from 1 at the first tick after the last clear. The generator fires in frame k exactly when floor(k·N/T) > floor((k−1)·N/T).
- R4: A generator that runs unscaled at 48000 Hz fires on every frame tick.
- R5: Each channel's generator is chosen by one bit of the control register: bit 8 for ADC left, bit 0 for ADC right, bit 10 for DAC left, and bit 2 for DAC right. A 0 picks generator 0 and a 1 picks generator 1. The output `chan_strobe` carries ADC left in bit 0, ADC right in bit 1, DAC left in bit 2 and DAC right in bit 3.
- R6: For generator 1, control bit 5 makes N = rate×8 and control bit 6 makes N = rate×10. Bit 6 wins if both are set. Generator 0 ignores both bits.
- R7: A write to a rate register clears that generator's accumulator and restarts its frame count. The other generator keeps its phase. A write to the control register clears neither generator.
- R8: Two channels of a stereo pair (ADC left and right, or DAC left and right) that select the same generator always strobe in the same clock cycle.
- R9: A strobe is high for exactly one clock cycle, the cycle after the frame tick that fires it. With no tick, no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per 48 kHz frame |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Register read data (combinational, zero for unmapped addresses) |
| chan_strobe | output | 4 | Per-channel sample strobes: ADC L, ADC R, DAC L, DAC R from bit 0 up |

## Verification
The bench drives long frame sequences and checks every frame of every channel against the floor-difference rule. A generator whose remainder handling is wrong would drift by a strobe within a few hundred frames, so a single tally at the end is not relied on. The bench reprograms a rate in the middle of a phase, which catches a design that keeps the stale remainder or clears the wrong generator. It also sets the scaling bits while pairs sit on generator 0, which catches scaling that leaks into generator 0. The 10/7 case at 33600 Hz lands exactly on the threshold, which catches an off-by-one comparison. Reserved control bits set to odd patterns catch decode that is too wide or readback that drops bits.

// File: rtl/srgen_pkg.sv
package srgen_pkg;
    localparam int RATE_W    = 16;
    localparam int ADDR_W    = 8;
    localparam int FRAME_HZ  = 48000;
    localparam int SCALE_DEN = 7;
    localparam int THRESH    = FRAME_HZ * SCALE_DEN;
    localparam int ACC_W     = $clog2(THRESH + (2 ** RATE_W) * 10);
    localparam int N_GEN     = 2;
    localparam int N_CHAN    = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h76;
    localparam logic [ADDR_W-1:0] ADDR_RATE0 = 8'h78;
    localparam logic [ADDR_W-1:0] ADDR_RATE1 = 8'h7A;

    localparam int CTL_ADC_R = 0;
    localparam int CTL_DAC_R = 2;
    localparam int CTL_MUL8  = 5;
    localparam int CTL_MUL10 = 6;
    localparam int CTL_ADC_L = 8;
    localparam int CTL_DAC_L = 10;

    localparam logic [RATE_W-1:0] RATE_RESET = RATE_W'(FRAME_HZ);

    typedef enum logic [1:0] {
        SCALE_UNITY = 2'd0,
        SCALE_8D7   = 2'd1,
        SCALE_10D7  = 2'd2
    } scale_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate0;
        logic [RATE_W-1:0] rate1;
        logic [RATE_W-1:0] ctrl;
    } regs_t;
endpackage

// File: rtl/srgen_regs.sv
module srgen_regs
    import srgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [RATE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RATE_W-1:0] rd_data,
    output logic [RATE_W-1:0] rate0,
    output logic [RATE_W-1:0] rate1,
    output logic [RATE_W-1:0] ctrl,
    output logic [N_GEN-1:0]  gen_clr
);
    regs_t regs_d, regs_q;
    logic  hit_ctrl, hit_r0, hit_r1;

    always_comb begin
        hit_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        hit_r0   = wr_en && (wr_addr == ADDR_RATE0);
        hit_r1   = wr_en && (wr_addr == ADDR_RATE1);
        regs_d   = regs_q;
        if (hit_ctrl) regs_d.ctrl  = wr_data;
        if (hit_r0)   regs_d.rate0 = wr_data;
        if (hit_r1)   regs_d.rate1 = wr_data;
        gen_clr  = {hit_r1, hit_r0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.rate0 <= RATE_RESET;
            regs_q.rate1 <= RATE_RESET;
            regs_q.ctrl  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTRL:  rd_data = regs_q.ctrl;
            ADDR_RATE0: rd_data = regs_q.rate0;
            ADDR_RATE1: rd_data = regs_q.rate1;
            default:    rd_data = '0;
        endcase
    end

    assign rate0 = regs_q.rate0;
    assign rate1 = regs_q.rate1;
    assign ctrl  = regs_q.ctrl;

    // R2: a write to the control address lands in full on the next edge
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL) |=> (ctrl == $past(wr_data)));
    // R2: a write to the generator-0 rate address lands on the next edge
    a_r2_rate0_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RATE0) |=> (rate0 == $past(wr_data)));
endmodule

// File: rtl/srgen_scale.sv
module srgen_scale
    import srgen_pkg::*;
#(
    parameter bit ALLOW_SCALE = 1'b0
) (
    input  logic [RATE_W-1:0] rate,
    input  logic              mul8,
    input  logic              mul10,
    output logic [ACC_W-1:0]  num
);
    logic [ACC_W-1:0] rate_x;
    scale_e           mode;

    assign rate_x = ACC_W'(rate);

    generate
        if (ALLOW_SCALE) begin : g_scaled
            always_comb begin
                if (mul10)     mode = SCALE_10D7;
                else if (mul8) mode = SCALE_8D7;
                else           mode = SCALE_UNITY;
            end
        end else begin : g_fixed
            logic unused_sel;
            assign unused_sel = mul8 ^ mul10;
            assign mode       = SCALE_UNITY;
        end
    endgenerate

    always_comb begin
        case (mode)
            SCALE_8D7:  num = (rate_x << 3);
            SCALE_10D7: num = (rate_x << 3) + (rate_x << 1);
            default:    num = (rate_x << 3) - rate_x;
        endcase
    end
endmodule

// File: rtl/srgen_accum.sv
module srgen_accum
    import srgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [ACC_W-1:0] num,
    output logic             strobe
);
    localparam logic [ACC_W-1:0] T = ACC_W'(THRESH);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             fire;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W-1:0] sum, rem;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        sum       = st_q.acc + num;
        rem       = sum - T;
        if (clr) begin
            st_d.acc = '0;
        end else if (tick) begin
            if (sum >= T) begin
                st_d.fire = 1'b1;
                st_d.acc  = (rem >= T) ? (T - 1'b1) : rem;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.fire;

    // R3: remainder always stays under the threshold
    a_r3_acc_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < T);
    // R7: a rate write leaves a zero phase and no strobe
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.acc == '0 && !strobe));
    // R9: a strobe only follows a tick
    a_r9_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(tick && !clr));
endmodule

// File: rtl/srgen_route.sv
module srgen_route
    import srgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CHAN-1:0] chan_sel,
    input  logic [N_GEN-1:0]  gen_strobe,
    output logic [N_CHAN-1:0] chan_strobe
);
    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            assign chan_strobe[c] = chan_sel[c] ? gen_strobe[1] : gen_strobe[0];
        end
    endgenerate

    // R8: ADC pair on one generator fires together
    a_r8_adc_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel[0] == chan_sel[1]) |-> (chan_strobe[0] == chan_strobe[1]));
    // R8: DAC pair on one generator fires together
    a_r8_dac_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel[2] == chan_sel[3]) |-> (chan_strobe[2] == chan_strobe[3]));
endmodule

// File: rtl/dual_srgen.sv
module dual_srgen
    import srgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [15:0]       rd_data,
    output logic [3:0]        chan_strobe
);
    logic [RATE_W-1:0] rate0, rate1, ctrl;
    logic [N_GEN-1:0]  gen_clr;
    logic [N_GEN-1:0]  gen_strobe;
    logic [RATE_W-1:0] gen_rate [N_GEN];
    logic [N_CHAN-1:0] chan_sel;

    srgen_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rate0   (rate0),
        .rate1   (rate1),
        .ctrl    (ctrl),
        .gen_clr (gen_clr)
    );

    assign gen_rate[0] = rate0;
    assign gen_rate[1] = rate1;

    generate
        for (genvar g = 0; g < N_GEN; g++) begin : g_gen
            logic [ACC_W-1:0] num;
            srgen_scale #(.ALLOW_SCALE(g == 1)) u_scale (
                .rate  (gen_rate[g]),
                .mul8  (ctrl[CTL_MUL8]),
                .mul10 (ctrl[CTL_MUL10]),
                .num   (num)
            );
            srgen_accum u_accum (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (frame_tick),
                .clr    (gen_clr[g]),
                .num    (num),
                .strobe (gen_strobe[g])
            );
        end
    endgenerate

    assign chan_sel = {ctrl[CTL_DAC_R], ctrl[CTL_DAC_L], ctrl[CTL_ADC_R], ctrl[CTL_ADC_L]};

    srgen_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_sel    (chan_sel),
        .gen_strobe  (gen_strobe),
        .chan_strobe (chan_strobe)
    );
endmodule

// File: tb/dual_srgen_bench.sv
module dual_srgen_bench;
    localparam longint T = 336000;

    logic        clk = 1'b0;
    logic        rst_n, frame_tick, wr_en;
    logic [7:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic [3:0]  chan_strobe;

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint rate_m [2];
    longint k_m    [2];
    int     ctrl_m;

    always #4 clk = ~clk;

    dual_srgen u_dual_srgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_tick  (frame_tick),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .chan_strobe (chan_strobe)
    );

    task automatic chk(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int gen_of(int c);
        int pos;
        pos = (c == 0) ? 8 : (c == 1) ? 0 : (c == 2) ? 10 : 2;
        return (ctrl_m >> pos) & 1;
    endfunction

    function automatic longint num_of(int g);
        if (g == 0) return rate_m[0] * 7;
        return rate_m[1] * (((ctrl_m >> 6) & 1) ? 10 : ((ctrl_m >> 5) & 1) ? 8 : 7);
    endfunction

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 8'h78) begin rate_m[0] = d; k_m[0] = 0; end
        if (a == 8'h7A) begin rate_m[1] = d; k_m[1] = 0; end
        if (a == 8'h76) ctrl_m = d;
    endtask

    task automatic rd(logic [7:0] a, longint exp, string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic frames(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_tick = 1'b1;
            @(negedge clk);
            frame_tick = 1'b0;
            k_m[0]++; k_m[1]++;
            for (int c = 0; c < 4; c++) begin
                int     g;
                longint nm, e;
                g  = gen_of(c);
                nm = num_of(g);
                e  = (((k_m[g] * nm) / T) != (((k_m[g] - 1) * nm) / T)) ? 1 : 0;
                chk(req, chan_strobe[c], e);
            end
            if (gen_of(0) == gen_of(1)) chk("R8", chan_strobe[0], chan_strobe[1]);
            if (gen_of(2) == gen_of(3)) chk("R8", chan_strobe[2], chan_strobe[3]);
            @(negedge clk);
            chk("R9", chan_strobe, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_tick = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        rate_m[0] = 48000; rate_m[1] = 48000; k_m[0] = 0; k_m[1] = 0; ctrl_m = 0;
        repeat (3) @(negedge clk);
        // R1: reset values and idle strobes
        rd(8'h78, 48000, "R1");
        rd(8'h7A, 48000, "R1");
        rd(8'h76, 0, "R1");
        chk("R1", chan_strobe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: no tick, no strobe
        repeat (5) @(negedge clk);
        chk("R9", chan_strobe, 0);
        // R4: unscaled 48 kHz fires every frame
        frames(12, "R4");
        // R3: two rates, pairs split across generators
        wr(8'h78, 16'd8000);
        wr(8'h7A, 16'd44100);
        wr(8'h76, 16'h0500);
        frames(200, "R3");
        // R5: mixed selects
        wr(8'h76, 16'h0005);
        frames(60, "R5");
        wr(8'h76, 16'h0104);
        frames(60, "R5");
        // R7: rewrite restarts only generator 1
        wr(8'h7A, 16'd44100);
        frames(40, "R7");
        wr(8'h78, 16'd11025);
        frames(40, "R7");
        // R6: 8/7 on generator 1, generator 0 unaffected
        wr(8'h76, 16'h0424);
        wr(8'h7A, 16'd7000);
        frames(100, "R6");
        // R6: 10/7 reaching exactly the frame rate
        wr(8'h76, 16'h0444);
        wr(8'h7A, 16'd33600);
        frames(20, "R6");
        wr(8'h7A, 16'd7000);
        frames(100, "R6");
        // R2: reserved bits retained, decode limited to the defined bits
        wr(8'h76, 16'hA9DB);
        rd(8'h76, 16'hA9DB, "R2");
        rd(8'h78, 11025, "R2");
        rd(8'h7A, 7000, "R2");
        rd(8'h50, 0, "R2");
        wr(8'h7A, 16'd22050);
        frames(60, "R2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule